// File: doc/BRIEF.md
# IQ Serial Output Framer

This block turns complex baseband sample pairs into a framed serial bit stream for a downstream receiver. A source hands over one pair with a single-cycle valid strobe: a 16-bit in-phase word, a 16-bit quadrature word, and two optional 8-bit side bytes (gain-control and status). The block sends each pair as one frame, MSB first. It drives a bit clock, a data line and a frame marker. The bit clock is the system clock divided by a 4-bit divider setting.

Two mode inputs change the frame layout. The first decides whether the two side bytes follow the quadrature word. The second replaces the separate frame-marker pulse with a low start bit on the data line. In that mode a guaranteed run of high idle bits comes before the start bit. The line idles high whenever no frame is in flight.

A pair that arrives while a frame is being sent waits in a one-deep holding register and goes out as the next frame. A pair that arrives while the holding register is already occupied is dropped, and a one-cycle overflow pulse reports it. Sample generation and filtering belong elsewhere.

Top module: `iqf_framer`

## Requirements
- R1: A frame payload carries the in-phase word and then the quadrature word, each MSB first. Payload bit 0 is in-phase bit 15, and payload bit 16 is quadrature bit 15.
- R2: With `cfg_aux_en` high when a frame starts, the payload grows to 48 bits. The gain byte follows the quadrature word, then the status byte, each MSB first. With it low, the payload is exactly 32 bits.
- R3: One bit period lasts d system clock cycles, where d is `cfg_div`, and a setting of 0 counts as 1. For d >= 2, `ser_clk` rises at the start of each bit and is high for (d+1)/2 cycles. For d = 1, `ser_clk` stays high.
- R4: `ser_dat` and `ser_fs` change only at the start of a bit period (a rising edge of `ser_clk` when d >= 2).
- R5: When no frame is being sent, `ser_dat` is 1 and `ser_fs` is 0.
- R6: With `cfg_emb_sync` low, `ser_fs` is high for exactly one bit period, the one just before the first payload bit, and `ser_dat` is 1 during that bit. A pending pair starts its marker bit right after the last payload bit of the previous frame.
- R7: With `cfg_emb_sync` high, `ser_fs` stays 0. Each frame starts with one low start bit. The start bit follows at least 10 high idle bits, and exactly 10 when a pair is already waiting.
- R8: A pair that arrives while a frame is in progress is sent unchanged in the next frame.
- R9: A pair that arrives while the holding register is full and not being emptied in that cycle is dropped. `ovf_pulse` is then high for exactly the one cycle after that arrival.
- R10: During reset, `ser_dat` = 1, `ser_fs` = 0, `ser_clk` = 1 and `ovf_pulse` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe: sample pair and side bytes are valid |
| smp_i | input | 16 | In-phase word, two's complement |
| smp_q | input | 16 | Quadrature word, two's complement |
| agc_byte | input | 8 | Gain-control side byte |
| stat_byte | input | 8 | Status side byte |
| cfg_div | input | 4 | Bit period in system clocks (0 counts as 1) |
| cfg_aux_en | input | 1 | Append the two side bytes to each frame |
| cfg_emb_sync | input | 1 | Use an in-band start bit instead of the marker pulse |
| ser_clk | output | 1 | Serial bit clock |
| ser_dat | output | 1 | Serial data, idle high |
| ser_fs | output | 1 | Frame marker pulse |
| ovf_pulse | output | 1 | One-cycle pulse when an arriving pair is dropped |

## Verification
The bench builds the block with its default parameters: 16-bit words, 8-bit side bytes, a 4-bit divider and a 10-bit idle gap. Because the divider is only four bits wide, every divider code from 0 to 15 is swept under all four combinations of side-byte and start-bit mode. Each run sends two frames back to back, so the second pair always arrives mid-frame. The bench rebuilds the bit stream from the rising edges of the output clock and compares the payload, the marker or start bit, the idle gap and the clock shape with values it computes itself. A separate run drives three pairs in a row to force and observe a drop.

// File: rtl/iqf_pkg.sv
package iqf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SYNC  = 2'd1,
    ST_START = 2'd2,
    ST_DATA  = 2'd3
  } fr_state_e;

  // divider setting to cycles per bit; zero behaves as one
  function automatic int unsigned eff_div(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // number of cycles the bit clock stays high in one bit period
  function automatic int unsigned clk_high_len(input int unsigned d);
    return (d + 1) / 2;
  endfunction

  // payload bits in one frame
  function automatic int unsigned payload_len(input bit aux,
                                              input int unsigned smp_w,
                                              input int unsigned aux_w);
    return 2 * smp_w + (aux ? 2 * aux_w : 0);
  endfunction

endpackage

// File: rtl/iqf_bitclk.sv
module iqf_bitclk #(
  parameter int W_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W_DIV-1:0] cfg_div,
  output logic             bit_end,
  output logic             ser_clk
);
  localparam int DW = W_DIV + 1;

  logic [W_DIV-1:0] ph;
  logic [W_DIV-1:0] ph_nxt;
  logic [DW-1:0]    d_eff;
  logic [DW-1:0]    hi_len;

  assign d_eff   = DW'(iqf_pkg::eff_div(32'(cfg_div)));
  assign hi_len  = DW'(iqf_pkg::clk_high_len(32'(d_eff)));
  assign bit_end = (({1'b0, ph} + DW'(1)) >= d_eff);
  assign ph_nxt  = bit_end ? '0 : ph + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= '0;
      ser_clk <= 1'b1;
    end else begin
      ph      <= ph_nxt;
      ser_clk <= ({1'b0, ph_nxt} < hi_len);
    end
  end

  // R3: the bit clock only rises as a new bit period begins
  a_r3_rise_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $past(bit_end));

endmodule

// File: rtl/iqf_hold.sv
module iqf_hold #(
  parameter int W_SMP = 16,
  parameter int W_AUX = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_vld,
  input  logic [W_SMP-1:0]           smp_i,
  input  logic [W_SMP-1:0]           smp_q,
  input  logic [W_AUX-1:0]           agc_byte,
  input  logic [W_AUX-1:0]           stat_byte,
  input  logic                       take,
  output logic                       full,
  output logic [2*W_SMP+2*W_AUX-1:0] pay,
  output logic                       ovf
);
  logic accept;
  logic drop;

  assign accept = smp_vld && (!full || take);
  assign drop   = smp_vld && full && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      pay  <= '0;
      ovf  <= 1'b0;
    end else begin
      ovf <= drop;
      if (accept) begin
        full <= 1'b1;
        pay  <= {smp_i, smp_q, agc_byte, stat_byte};
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  // R8: a waiting pair stays intact until the sequencer takes it
  a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(pay)));

  // R9: a drop leaves the earlier pair still waiting
  a_r9_ovf_held: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> full);

endmodule

// File: rtl/iqf_seq.sv
module iqf_seq #(
  parameter int W_SMP    = 16,
  parameter int W_AUX    = 8,
  parameter int IDLE_MIN = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_end,
  input  logic                       cfg_aux_en,
  input  logic                       cfg_emb_sync,
  input  logic                       hold_full,
  input  logic [2*W_SMP+2*W_AUX-1:0] hold_pay,
  output logic                       take,
  output logic                       ser_dat,
  output logic                       ser_fs
);
  import iqf_pkg::*;

  localparam int PAY_W = 2 * W_SMP + 2 * W_AUX;
  localparam int IW    = $clog2(PAY_W);
  localparam int CW    = $clog2(IDLE_MIN + 1);

  fr_state_e        st;
  fr_state_e        nst;
  fr_state_e        launch_st;
  logic [PAY_W-1:0] sh;
  logic [IW-1:0]    idx;
  logic [IW-1:0]    len_m1;
  logic [CW-1:0]    idle_cnt;
  logic             aux_q;
  logic             launch_ok;
  logic             launch;

  assign len_m1    = IW'(payload_len(aux_q, W_SMP, W_AUX) - 1);
  assign launch_ok = hold_full && (!cfg_emb_sync || (idle_cnt >= CW'(IDLE_MIN)));
  assign launch_st = cfg_emb_sync ? ST_START : ST_SYNC;

  always_comb begin
    nst = st;
    unique case (st)
      ST_SYNC, ST_START: nst = ST_DATA;
      ST_DATA: begin
        if (idx != len_m1) nst = ST_DATA;
        else               nst = launch_ok ? launch_st : ST_IDLE;
      end
      default: nst = launch_ok ? launch_st : ST_IDLE;
    endcase
  end

  assign launch = (nst == ST_SYNC) || (nst == ST_START);
  assign take   = bit_end && launch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sh       <= '0;
      idx      <= '0;
      idle_cnt <= CW'(IDLE_MIN);
      aux_q    <= 1'b0;
      ser_dat  <= 1'b1;
      ser_fs   <= 1'b0;
    end else if (bit_end) begin
      st <= nst;
      unique case (nst)
        ST_IDLE: begin
          ser_dat <= 1'b1;
          ser_fs  <= 1'b0;
          if (idle_cnt != CW'(IDLE_MIN)) idle_cnt <= idle_cnt + 1'b1;
        end
        ST_SYNC, ST_START: begin
          ser_dat  <= (nst == ST_SYNC);
          ser_fs   <= (nst == ST_SYNC);
          sh       <= hold_pay;
          aux_q    <= cfg_aux_en;
          idx      <= '0;
          idle_cnt <= '0;
        end
        default: begin
          ser_dat <= sh[PAY_W-1];
          ser_fs  <= 1'b0;
          sh      <= {sh[PAY_W-2:0], 1'b0};
          if (st == ST_DATA) idx <= idx + 1'b1;
        end
      endcase
    end
  end

  // R6: the marker lasts a single bit period
  a_r6_fs_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_fs && bit_end) |=> !ser_fs);

  // R6: the data line is high during the marker bit
  a_r6_fs_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    ser_fs |-> ser_dat);

  // R5: idle periods keep the line high with no marker
  a_r5_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (ser_dat && !ser_fs));

  // R2: the payload index never runs past the selected length
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA) |-> (idx <= len_m1));

endmodule

// File: rtl/iqf_framer.sv
module iqf_framer #(
  parameter int W_SMP    = 16,
  parameter int W_AUX    = 8,
  parameter int W_DIV    = 4,
  parameter int IDLE_MIN = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [W_SMP-1:0] smp_i,
  input  logic [W_SMP-1:0] smp_q,
  input  logic [W_AUX-1:0] agc_byte,
  input  logic [W_AUX-1:0] stat_byte,
  input  logic [W_DIV-1:0] cfg_div,
  input  logic             cfg_aux_en,
  input  logic             cfg_emb_sync,
  output logic             ser_clk,
  output logic             ser_dat,
  output logic             ser_fs,
  output logic             ovf_pulse
);
  localparam int PAY_W = 2 * W_SMP + 2 * W_AUX;

  logic             bit_end;
  logic             take;
  logic             hold_full;
  logic [PAY_W-1:0] hold_pay;

  iqf_bitclk #(.W_DIV(W_DIV)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_div (cfg_div),
    .bit_end (bit_end),
    .ser_clk (ser_clk)
  );

  iqf_hold #(.W_SMP(W_SMP), .W_AUX(W_AUX)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .smp_i     (smp_i),
    .smp_q     (smp_q),
    .agc_byte  (agc_byte),
    .stat_byte (stat_byte),
    .take      (take),
    .full      (hold_full),
    .pay       (hold_pay),
    .ovf       (ovf_pulse)
  );

  iqf_seq #(.W_SMP(W_SMP), .W_AUX(W_AUX), .IDLE_MIN(IDLE_MIN)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_end      (bit_end),
    .cfg_aux_en   (cfg_aux_en),
    .cfg_emb_sync (cfg_emb_sync),
    .hold_full    (hold_full),
    .hold_pay     (hold_pay),
    .take         (take),
    .ser_dat      (ser_dat),
    .ser_fs       (ser_fs)
  );

  // R4: the data and marker lines only move when a bit period starts
  a_r4_dat_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ser_dat) || !$stable(ser_fs)) |-> $past(bit_end));

endmodule

// File: tb/sim_iqf_framer.sv
`timescale 1ns/1ps
module sim_iqf_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [15:0] smp_i = '0, smp_q = '0;
  logic [7:0] agc_byte = '0, stat_byte = '0;
  logic [3:0] cfg_div = 4'd1;
  logic cfg_aux_en = 1'b0, cfg_emb_sync = 1'b0;
  logic ser_clk, ser_dat, ser_fs, ovf_pulse;

  always #4 clk = ~clk;

  iqf_framer u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
    .agc_byte(agc_byte), .stat_byte(stat_byte), .cfg_div(cfg_div),
    .cfg_aux_en(cfg_aux_en), .cfg_emb_sync(cfg_emb_sync),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_fs(ser_fs), .ovf_pulse(ovf_pulse)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  logic bd [0:511];
  logic bf [0:511];
  int nbits = 0;
  int eff_d = 1;
  int clk_err = 0;
  int chg_err = 0;
  logic pclk = 1'b1, pdat = 1'b1, pfs = 1'b0;
  bit seen_rise = 0;
  int since = 0, hi_cnt = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (div=%0d aux=%0b emb=%0b)",
               tag, act, exp, cfg_div, cfg_aux_en, cfg_emb_sync);
    end
  endtask

  // stream monitor: one record per bit period, plus clock shape checks
  always @(negedge clk) begin
    if (!rst_n) begin
      nbits = 0; pclk = 1'b1; pdat = 1'b1; pfs = 1'b0;
      seen_rise = 0; since = 0; hi_cnt = 0;
    end else begin
      bit newbit;
      newbit = (eff_d == 1) ? 1'b1 : (ser_clk && !pclk);
      if (eff_d == 1) begin
        if (ser_clk !== 1'b1) clk_err++;
      end else if (newbit) begin
        if (seen_rise && since != eff_d) clk_err++;
        if (seen_rise && hi_cnt != (eff_d + 1) / 2) clk_err++;
        seen_rise = 1; since = 1; hi_cnt = 1;
      end else begin
        since++;
        if (ser_clk) hi_cnt++;
      end
      if (!newbit && (ser_dat !== pdat || ser_fs !== pfs)) chg_err++;
      if (newbit && nbits < 512) begin
        bd[nbits] = ser_dat; bf[nbits] = ser_fs; nbits++;
      end
      pclk = ser_clk; pdat = ser_dat; pfs = ser_fs;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic do_reset(input int div, input bit aux, input bit emb);
    @(negedge clk);
    rst_n = 1'b0; cfg_div = 4'(div); cfg_aux_en = aux; cfg_emb_sync = emb;
    eff_d = (div == 0) ? 1 : div;
    clk_err = 0; chg_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [47:0] p);
    @(negedge clk);
    {smp_i, smp_q, agc_byte, stat_byte} = p;
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  function automatic logic [47:0] grab(input int p, input int n);
    logic [47:0] v = '0;
    for (int k = 0; k < n; k++) v = {v[46:0], bd[p + k]};
    return v;
  endfunction

  // parse one frame at position p; gap < 0 means do not check the idle run
  task automatic frame(inout int p, input logic [47:0] exp, input bit aux,
                       input bit emb, input int gap);
    int run = 0;
    int len = aux ? 48 : 32;
    bit fs_in_pay = 0;
    while (p < nbits && bd[p] === 1'b1 && bf[p] === 1'b0) begin run++; p++; end
    if (gap >= 0) chg_gap(run, gap, emb);
    if (!emb) chk(bf[p] === 1'b1 && bd[p] === 1'b1, "R6 marker bit", {bf[p], bd[p]}, 2'b11);
    else      chk(bf[p] === 1'b0 && bd[p] === 1'b0, "R7 start bit", {bf[p], bd[p]}, 2'b00);
    p++;
    chk(grab(p, 16) == {32'd0, exp[47:32]}, "R1 in-phase word", grab(p, 16), exp[47:32]);
    chk(grab(p + 16, 16) == {32'd0, exp[31:16]}, "R1 quadrature word",
        grab(p + 16, 16), exp[31:16]);
    if (aux) chk(grab(p + 32, 16) == {32'd0, exp[15:0]}, "R2 side bytes",
                 grab(p + 32, 16), exp[15:0]);
    for (int k = 0; k < len; k++) if (bf[p + k] !== 1'b0) fs_in_pay = 1;
    chk(!fs_in_pay, "R6 R7 no marker in payload", fs_in_pay, 0);
    p += len;
  endtask

  task automatic chg_gap(input int run, input int gap, input bit emb);
    if (emb) chk(run == gap, "R7 idle gap before start bit", run, gap);
    else     chk(run == gap, "R6 back-to-back marker", run, gap);
  endtask

  task automatic tail(input int p, input string tag);
    bit bad = 0;
    for (int k = p; k < nbits; k++) if (bd[k] !== 1'b1 || bf[k] !== 1'b0) bad = 1;
    chk(!bad && (nbits - p) >= 2, tag, nbits - p, 2);
  endtask

  task automatic run_cfg(input int div, input bit aux, input bit emb, input int seed);
    logic [47:0] pa, pb;
    int d, len, p;
    d = (div == 0) ? 1 : div;
    len = aux ? 48 : 32;
    pa = {16'(seed * 4111 + 16'h8001), 16'(seed * 263 + 7), 8'(seed * 13 + 1), 8'hA5 ^ 8'(seed)};
    pb = ~pa ^ {16'(seed), 32'h0F0F_3C3C};
    do_reset(div, aux, emb);
    repeat (2 * d + 2) @(negedge clk);
    send(pa);
    repeat (2 * d + 3) @(negedge clk);
    send(pb);                                     // arrives mid-frame: R8
    repeat (d * (2 * (len + 12) + 8)) @(negedge clk);
    p = 0;
    frame(p, pa, aux, emb, -1);
    frame(p, pb, aux, emb, emb ? 10 : 0);        // R8 second pair intact
    tail(p, "R5 idle after frames");
    chk(clk_err == 0, "R3 bit clock shape", clk_err, 0);
    chk(chg_err == 0, "R4 lines move only at bit start", chg_err, 0);
  endtask

  initial begin
    int seed = 0;
    // R10: reset values
    repeat (2) @(negedge clk);
    chk(ser_dat === 1'b1, "R10 reset ser_dat", ser_dat, 1);
    chk(ser_fs === 1'b0, "R10 reset ser_fs", ser_fs, 0);
    chk(ser_clk === 1'b1, "R10 reset ser_clk", ser_clk, 1);
    chk(ovf_pulse === 1'b0, "R10 reset ovf_pulse", ovf_pulse, 0);

    for (int m = 0; m < 4; m++)
      for (int dv = 0; dv < 16; dv++) begin
        run_cfg(dv, m[0], m[1], seed);
        seed++;
      end

    // R9: overflow with a full holding register
    begin
      logic [47:0] pa, pb, pc;
      int p, waitc;
      pa = 48'h1234_8765_5A3C; pb = 48'hFEDC_0123_C35A; pc = 48'h0F0F_F0F0_9966;
      do_reset(4, 0, 0);
      repeat (4) @(negedge clk);
      send(pa);
      waitc = 0;
      while (ser_fs !== 1'b1 && waitc < 100) begin @(negedge clk); waitc++; end
      @(negedge clk);
      {smp_i, smp_q, agc_byte, stat_byte} = pb; smp_vld = 1'b1;
      @(negedge clk);
      chk(ovf_pulse === 1'b0, "R9 no overflow on first waiting pair", ovf_pulse, 0);
      {smp_i, smp_q, agc_byte, stat_byte} = pc;
      @(negedge clk);
      smp_vld = 1'b0;
      chk(ovf_pulse === 1'b1, "R9 overflow pulse", ovf_pulse, 1);
      @(negedge clk);
      chk(ovf_pulse === 1'b0, "R9 overflow lasts one cycle", ovf_pulse, 0);
      repeat (4 * 120) @(negedge clk);
      p = 0;
      frame(p, pa, 0, 0, -1);
      frame(p, pb, 0, 0, 0);
      tail(p, "R9 dropped pair never sent");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule